// File: doc/BRIEF.md
# Mode-Aware Segment Address Generator

This block forms a linear address from a segment slot and an effective address and flags accesses that break the segment rules. It keeps a base and a limit for six segment slots. A single write port loads these values. A two-state mode machine selects one of two modes. In the legacy (compatibility) mode, every slot adds its base and enforces its 32-bit limit. In the flat 64-bit mode, four slots contribute no base, the other two still add their full 64-bit base, and no fault is raised.

Each request carries a slot index, a 64-bit effective address and an access size. One clock later the block returns the linear address, a fault flag and a valid strobe. The linear address is reported even when the fault flag is set, so a trap handler can record it.

The mode machine has two states. `MODE_COMPAT` is the reset state. `MODE_FLAT` is the 64-bit state. When `mode_we_i` is high, the machine takes the transition `COMPAT_TO_FLAT` if `mode_flat_i` is 1, or `FLAT_TO_COMPAT` if `mode_flat_i` is 0. Otherwise it holds its current state.

Top module: `seg_agu`

## Requirements
- R1: After a synchronous reset, `rsp_valid_o` is 0, every base is 0, every limit is 0xFFFFFFFF and the mode is compatibility.
- R2: `rsp_valid_o` is 1 in the cycle after a cycle with `req_valid_i` high, and 0 otherwise.
- R3: In compatibility mode, `rsp_lin_o` is the low 32 bits of (slot base + low 32 bits of the offset), with bits 63:32 at zero.
- R4: In compatibility mode, `rsp_fault_o` is 1 exactly when offset[31:0] + bytes − 1, computed without overflow, is greater than the slot limit. The linear address is still reported when this fault is raised.
- R5: `req_size_i` encodes the access width as 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes.
- R6: The slot index encoding is 0=ES, 1=CS, 2=SS, 3=DS, 4=FS, 5=GS. In compatibility mode, index 6 or 7 raises the fault, with the linear address formed using a zero base. A write to index 6 or 7 is ignored.
- R7: In flat mode, slots 0 to 3 use a zero base, so `rsp_lin_o` equals the offset.
- R8: In flat mode, slots 4 and 5 give `rsp_lin_o` = stored 64-bit base + offset, modulo 2^64. Indices 6 and 7 give the offset.
- R9: In flat mode, `rsp_fault_o` is never 1.
- R10: A base/limit write and a request to the same slot in the same cycle use the old values. The new values apply from the next cycle.
- R11: A mode write (`mode_we_i`, with `mode_flat_i` 1 for flat) changes the mode from the next cycle. A request in the same cycle uses the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_we_i | input | 1 | Mode write strobe |
| mode_flat_i | input | 1 | Mode value to write: 1 = flat 64-bit, 0 = compatibility |
| wr_en_i | input | 1 | Slot write strobe |
| wr_seg_i | input | 3 | Slot index to write |
| wr_base_i | input | 64 | Base value to write |
| wr_limit_i | input | 32 | Limit value to write |
| req_valid_i | input | 1 | Request strobe |
| req_seg_i | input | 3 | Slot index of the request |
| req_off_i | input | 64 | Effective address |
| req_size_i | input | 2 | Access size code |
| rsp_valid_o | output | 1 | Result valid |
| rsp_lin_o | output | 64 | Linear address |
| rsp_fault_o | output | 1 | Fault flag |

## Verification
All three results of a request are due exactly one clock edge after the request is accepted. A slot write or a mode write made in that same cycle affects only the requests that come after it.

The bench drives each request on a falling edge and samples the outputs 2 ns after the next rising edge. It computes the expected values from its own model of the slots and the mode. It updates that model with the cycle's writes only after the check, which keeps the old-values-first ordering.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;

    localparam int SEG_IDX_W   = 3;
    localparam int SEG_COUNT   = 6;
    localparam int LIN_W       = 64;
    localparam int COMPAT_W    = 32;
    localparam int SIZE_W      = 2;

    // Slots that keep their base in flat mode (FS = 4, GS = 5)
    localparam logic [SEG_COUNT-1:0] FLAT_BASE_KEEP = 6'b11_0000;

    typedef enum logic [0:0] {
        MODE_COMPAT = 1'b0,
        MODE_FLAT   = 1'b1
    } mode_state_e;

    // Access size code to (bytes - 1)
    function automatic logic [3:0] size_extent(input logic [SIZE_W-1:0] code);
        logic [3:0] ext;
        unique case (code)
            2'd0: ext = 4'd0;
            2'd1: ext = 4'd1;
            2'd2: ext = 4'd3;
            default: ext = 4'd7;
        endcase
        return ext;
    endfunction

endpackage

// File: rtl/seg_agu_mode_fsm.sv
module seg_agu_mode_fsm
    import seg_agu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_we_i,
    input  logic mode_flat_i,
    output logic flat_o
);

    mode_state_e state_q;
    mode_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MODE_COMPAT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: COMPAT_TO_FLAT, FLAT_TO_COMPAT, otherwise hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_COMPAT: begin
                if (mode_we_i && mode_flat_i) begin
                    state_d = MODE_FLAT;
                end
            end
            MODE_FLAT: begin
                if (mode_we_i && !mode_flat_i) begin
                    state_d = MODE_COMPAT;
                end
            end
            default: state_d = MODE_COMPAT;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            MODE_FLAT:   flat_o = 1'b1;
            MODE_COMPAT: flat_o = 1'b0;
            default:     flat_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/seg_agu_regs.sv
module seg_agu_regs #(
    parameter int NSEG  = 6,
    parameter int IDX_W = 3,
    parameter int BASE_W = 64,
    parameter int LIM_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [BASE_W-1:0] wr_base_i,
    input  logic [LIM_W-1:0]  wr_limit_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [BASE_W-1:0] rd_base_o,
    output logic [LIM_W-1:0]  rd_limit_o,
    output logic              rd_hit_o
);

    logic [BASE_W-1:0] base_q  [NSEG];
    logic [LIM_W-1:0]  limit_q [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT_ID = IDX_W'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[g]  <= '0;
                limit_q[g] <= '1;
            end else if (wr_en_i && (wr_idx_i == SLOT_ID)) begin
                base_q[g]  <= wr_base_i;
                limit_q[g] <= wr_limit_i;
            end
        end
    end

    // Read port sees the values before this cycle's write
    always_comb begin
        rd_base_o  = '0;
        rd_limit_o = '0;
        rd_hit_o   = 1'b0;
        for (int i = 0; i < NSEG; i++) begin
            if (rd_idx_i == IDX_W'(i)) begin
                rd_base_o  = base_q[i];
                rd_limit_o = limit_q[i];
                rd_hit_o   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/seg_agu_calc.sv
module seg_agu_calc
    import seg_agu_pkg::*;
#(
    parameter int NSEG   = 6,
    parameter int IDX_W  = 3,
    parameter int LIN_WD = 64,
    parameter int CMP_W  = 32,
    parameter logic [NSEG-1:0] KEEP_MASK = FLAT_BASE_KEEP
) (
    input  logic              flat_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              hit_i,
    input  logic [LIN_WD-1:0] off_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [LIN_WD-1:0] base_i,
    input  logic [CMP_W-1:0]  limit_i,
    output logic [LIN_WD-1:0] lin_o,
    output logic              fault_o
);

    localparam int EXT_W = CMP_W + 1;

    logic              keep_base;
    logic [CMP_W-1:0]  compat_sum;
    logic [EXT_W-1:0]  last_byte;
    logic              over_limit;

    always_comb begin
        keep_base = 1'b0;
        for (int i = 0; i < NSEG; i++) begin
            if (idx_i == IDX_W'(i)) begin
                keep_base = KEEP_MASK[i];
            end
        end
    end

    assign compat_sum = base_i[CMP_W-1:0] + off_i[CMP_W-1:0];
    assign last_byte  = {1'b0, off_i[CMP_W-1:0]} + EXT_W'(size_extent(size_i));
    assign over_limit = last_byte > {1'b0, limit_i};

    always_comb begin
        if (flat_i) begin
            lin_o   = keep_base ? (base_i + off_i) : off_i;
            fault_o = 1'b0;
        end else begin
            lin_o   = {{(LIN_WD-CMP_W){1'b0}}, compat_sum};
            fault_o = !hit_i || over_limit;
        end
    end

endmodule

// File: rtl/seg_agu.sv
module seg_agu
    import seg_agu_pkg::*;
#(
    parameter int NSEG   = SEG_COUNT,
    parameter int IDX_W  = SEG_IDX_W,
    parameter int LIN_WD = LIN_W,
    parameter int CMP_W  = COMPAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we_i,
    input  logic              mode_flat_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_seg_i,
    input  logic [LIN_WD-1:0] wr_base_i,
    input  logic [CMP_W-1:0]  wr_limit_i,
    input  logic              req_valid_i,
    input  logic [IDX_W-1:0]  req_seg_i,
    input  logic [LIN_WD-1:0] req_off_i,
    input  logic [SIZE_W-1:0] req_size_i,
    output logic              rsp_valid_o,
    output logic [LIN_WD-1:0] rsp_lin_o,
    output logic              rsp_fault_o
);

    logic              flat_q;
    logic [LIN_WD-1:0] sel_base;
    logic [CMP_W-1:0]  sel_limit;
    logic              sel_hit;
    logic [LIN_WD-1:0] lin_d;
    logic              fault_d;

    seg_agu_mode_fsm u_mode (
        .clk         (clk),
        .rst         (rst),
        .mode_we_i   (mode_we_i),
        .mode_flat_i (mode_flat_i),
        .flat_o      (flat_q)
    );

    seg_agu_regs #(
        .NSEG   (NSEG),
        .IDX_W  (IDX_W),
        .BASE_W (LIN_WD),
        .LIM_W  (CMP_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en_i),
        .wr_idx_i   (wr_seg_i),
        .wr_base_i  (wr_base_i),
        .wr_limit_i (wr_limit_i),
        .rd_idx_i   (req_seg_i),
        .rd_base_o  (sel_base),
        .rd_limit_o (sel_limit),
        .rd_hit_o   (sel_hit)
    );

    seg_agu_calc #(
        .NSEG   (NSEG),
        .IDX_W  (IDX_W),
        .LIN_WD (LIN_WD),
        .CMP_W  (CMP_W)
    ) u_calc (
        .flat_i  (flat_q),
        .idx_i   (req_seg_i),
        .hit_i   (sel_hit),
        .off_i   (req_off_i),
        .size_i  (req_size_i),
        .base_i  (sel_base),
        .limit_i (sel_limit),
        .lin_o   (lin_d),
        .fault_o (fault_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            rsp_lin_o   <= '0;
            rsp_fault_o <= 1'b0;
        end else begin
            rsp_valid_o <= req_valid_i;
            if (req_valid_i) begin
                rsp_lin_o   <= lin_d;
                rsp_fault_o <= fault_d;
            end
        end
    end

endmodule

// File: rtl/seg_agu_chk.sv
module seg_agu_chk #(
    parameter int IDX_W  = 3,
    parameter int LIN_WD = 64,
    parameter int CMP_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_we_i,
    input logic              mode_flat_i,
    input logic              req_valid_i,
    input logic [IDX_W-1:0]  req_seg_i,
    input logic [LIN_WD-1:0] req_off_i,
    input logic              rsp_valid_o,
    input logic [LIN_WD-1:0] rsp_lin_o,
    input logic              rsp_fault_o,
    input logic              flat_q
);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> rsp_valid_o); // R2

    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> !rsp_valid_o); // R2

    AST_COMPAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !flat_q) |=> (rsp_lin_o[LIN_WD-1:CMP_W] == '0)); // R3

    AST_BAD_IDX_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !flat_q && (req_seg_i >= IDX_W'(6))) |=> rsp_fault_o); // R6

    AST_FLAT_ZERO_BASE: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && flat_q && (req_seg_i < IDX_W'(4))) |=> (rsp_lin_o == $past(req_off_i))); // R7

    AST_FLAT_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && flat_q) |=> !rsp_fault_o); // R9

    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (rst)
        mode_we_i |=> (flat_q == $past(mode_flat_i))); // R11

endmodule

bind seg_agu seg_agu_chk #(
    .IDX_W  (IDX_W),
    .LIN_WD (LIN_WD),
    .CMP_W  (CMP_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_we_i   (mode_we_i),
    .mode_flat_i (mode_flat_i),
    .req_valid_i (req_valid_i),
    .req_seg_i   (req_seg_i),
    .req_off_i   (req_off_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_lin_o   (rsp_lin_o),
    .rsp_fault_o (rsp_fault_o),
    .flat_q      (flat_q)
);

// File: tb/seg_agu_bench.sv
`timescale 1ns/1ps
module seg_agu_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_we_i = 1'b0;
    logic        mode_flat_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_seg_i = '0;
    logic [63:0] wr_base_i = '0;
    logic [31:0] wr_limit_i = '0;
    logic        req_valid_i = 1'b0;
    logic [2:0]  req_seg_i = '0;
    logic [63:0] req_off_i = '0;
    logic [1:0]  req_size_i = '0;
    logic        rsp_valid_o;
    logic [63:0] rsp_lin_o;
    logic        rsp_fault_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [63:0] m_base  [6];
    logic [31:0] m_limit [6];
    bit          m_flat;

    always #4 clk = ~clk;

    seg_agu u_seg_agu (
        .clk(clk), .rst(rst), .mode_we_i(mode_we_i), .mode_flat_i(mode_flat_i),
        .wr_en_i(wr_en_i), .wr_seg_i(wr_seg_i), .wr_base_i(wr_base_i),
        .wr_limit_i(wr_limit_i), .req_valid_i(req_valid_i), .req_seg_i(req_seg_i),
        .req_off_i(req_off_i), .req_size_i(req_size_i), .rsp_valid_o(rsp_valid_o),
        .rsp_lin_o(rsp_lin_o), .rsp_fault_o(rsp_fault_o)
    );

    function automatic logic [64:0] expect_rsp(input logic [2:0] idx,
                                                input logic [63:0] off,
                                                input logic [1:0] size);
        logic [63:0] base;
        logic [31:0] lim;
        logic [32:0] last;
        logic [31:0] sum;
        bit ok;
        ok   = (idx < 3'd6);
        base = ok ? m_base[idx] : 64'd0;
        lim  = ok ? m_limit[idx] : 32'd0;
        if (m_flat) begin
            if (idx == 3'd4 || idx == 3'd5) return {1'b0, base + off};
            return {1'b0, off};
        end
        sum  = base[31:0] + off[31:0];
        last = {1'b0, off[31:0]} + 33'((1 << size) - 1);
        return {(!ok || (last > {1'b0, lim})), 32'd0, sum};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: inputs are set at a falling edge, outputs sampled after the rising edge
    task automatic step(input string tag);
        logic [64:0] e;
        bit had_req;
        had_req = req_valid_i;
        e = expect_rsp(req_seg_i, req_off_i, req_size_i);
        @(posedge clk);
        #2;
        check({tag, " valid (R2)"}, 64'(rsp_valid_o), 64'(had_req));
        if (had_req) begin
            check({tag, " lin"}, rsp_lin_o, e[63:0]);
            check({tag, " fault"}, 64'(rsp_fault_o), 64'(e[64]));
        end
        if (wr_en_i && wr_seg_i < 3'd6) begin
            m_base[wr_seg_i]  = wr_base_i;
            m_limit[wr_seg_i] = wr_limit_i;
        end
        if (mode_we_i) m_flat = mode_flat_i;
        @(negedge clk);
        req_valid_i = 1'b0;
        wr_en_i     = 1'b0;
        mode_we_i   = 1'b0;
    endtask

    task automatic req(input logic [2:0] idx, input logic [63:0] off, input logic [1:0] sz);
        req_valid_i = 1'b1;
        req_seg_i   = idx;
        req_off_i   = off;
        req_size_i  = sz;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [63:0] b, input logic [31:0] l);
        wr_en_i    = 1'b1;
        wr_seg_i   = idx;
        wr_base_i  = b;
        wr_limit_i = l;
    endtask

    task automatic set_mode(input bit flat);
        mode_we_i   = 1'b1;
        mode_flat_i = flat;
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'd4711);
        for (int i = 0; i < 6; i++) begin
            m_base[i]  = '0;
            m_limit[i] = '1;
        end
        m_flat = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check("R1 reset valid", 64'(rsp_valid_o), 64'd0);
        @(negedge clk);

        // R1: reset limits of all ones; R4/R5 boundary per size
        req(3'd3, 64'hFFFF_FFFF_FFFF_FFFC, 2'd2); step("R1 top dword fits");
        req(3'd3, 64'h0000_0000_FFFF_FFFD, 2'd2); step("R4 crosses 4G");
        wr(3'd1, 64'h0000_0001_0000_1000, 32'h0000_00FF); step("R3 write CS");
        req(3'd1, 64'h0000_00FF, 2'd0); step("R5 1 byte at limit");
        req(3'd1, 64'h0000_00FF, 2'd1); step("R5 2 bytes past limit");
        req(3'd1, 64'h0000_00FC, 2'd2); step("R5 4 bytes at limit");
        req(3'd1, 64'h0000_00F8, 2'd3); step("R5 8 bytes at limit");
        req(3'd1, 64'h0000_00F9, 2'd3); step("R5 8 bytes past limit");
        req(3'd1, 64'hABCD_0000_0000_0010, 2'd0); step("R3 upper offset dropped");
        // R6: invalid index, ignored write
        wr(3'd6, 64'h1234, 32'h0); step("R6 write idx6");
        req(3'd6, 64'h40, 2'd0); step("R6 idx6 faults");
        req(3'd7, 64'h40, 2'd0); step("R6 idx7 faults");
        // R10: same-cycle write and lookup
        wr(3'd2, 64'h0000_0000_0000_5000, 32'h10); req(3'd2, 64'h20, 2'd0); step("R10 old values");
        req(3'd2, 64'h20, 2'd0); step("R10 new values");
        // R11: mode write with request in the same cycle
        wr(3'd4, 64'hFFFF_0000_0000_0100, 32'h0); step("R8 write FS");
        set_mode(1'b1); req(3'd4, 64'h10, 2'd0); step("R11 old mode");
        req(3'd4, 64'h10, 2'd0); step("R8 FS base kept");
        wr(3'd5, 64'hFFFF_FFFF_FFFF_FFF0, 32'h0); step("R8 write GS");
        req(3'd5, 64'h20, 2'd3); step("R8 GS wraps");
        req(3'd2, 64'h1234_5678_9ABC_DEF0, 2'd3); step("R7 SS base zero");
        req(3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3); step("R9 no limit fault");
        req(3'd7, 64'h77, 2'd0); step("R9 idx7 flat");
        set_mode(1'b0); step("R11 back to compat");
        req(3'd4, 64'h10, 2'd0); step("R3 FS low half");

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            r = $urandom % 16;
            if (r < 3) begin
                logic [2:0] s;
                s = 3'($urandom % 7);
                wr(s, {$urandom, $urandom}, (r == 0) ? 32'hFFFF_FFFF : ($urandom % 32'h2000));
            end
            if (r == 5) set_mode(1'($urandom % 2));
            if ($urandom % 4 != 0) begin
                logic [2:0] s2;
                logic [63:0] o;
                s2 = 3'($urandom % 8);
                o  = ($urandom % 2) ? {$urandom, $urandom} : 64'($urandom % 32'h2010);
                req(s2, o, 2'($urandom % 4));
            end
            step(m_flat ? "R7/R8/R9 random" : "R3/R4/R6 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule